// File: doc/BRIEF.md
# Ten-Slot Shared RAM Arbiter

This block lets eight processor cores and one external-memory DMA engine share a single on-chip RAM without any request ever competing with another. A free-running slot counter walks a fixed ten-step rotation. Each step belongs to exactly one requester, so each requester always knows where its access will fall. The eight cores own one step each. The DMA engine owns two steps, placed evenly: one after the first four cores and one after the last four.

The RAM is one line of eight 32-bit longs (256 bits) wide. A DMA step therefore reads or writes a whole 32-byte line in one access. A core step reads or writes one long, and the three low bits of the core's long address pick the lane inside the line. In a core write, the per-byte enables pick the bytes within that long.

A requester raises its request and holds it steady. When the rotation reaches its step, the access happens. In the following clock the requester sees its acknowledge, together with read data and the index of the step that served it. If the step's owner has no request, the step goes unused; it is never lent to another requester.

Top module: `hub_slot_arbiter`

## Requirements
- R1: A synchronous active-high reset forces the slot index to 0 and clears every acknowledge; in the first clock after reset is released, the slot index is 0.
- R2: The slot index advances by one on every clock and wraps from 9 back to 0. Slots 0 to 3 belong to cores 0 to 3, slot 4 to the DMA port, slots 5 to 8 to cores 4 to 7, and slot 9 to the DMA port.
- R3: A core is served only in its own slot. The acknowledge for core k appears on bit k of `core_ack`, and only in the clock after a slot owned by core k in which core k was requesting.
- R4: A requesting slot owner is acknowledged exactly one clock after its slot, and at most one acknowledge (any core bit or `dma_ack`) is high in any clock.
- R5: When the owner of a slot is not requesting, that slot produces no acknowledge of any kind in the following clock, even if other requesters are waiting.
- R6: A core write changes only the long at its address. Bit i of its 4-bit byte enable writes byte i (bits 8i+7..8i) of that long, and a clear bit leaves that byte unchanged.
- R7: A core read returns on `core_rdata` the long stored at its address, where the long address is line index times 8 plus lane.
- R8: A DMA write stores all eight longs of `dma_wdata` into one line in a single slot: long j comes from bits 32j+31..32j and becomes visible to cores at long address line*8+j.
- R9: A DMA read returns the whole addressed line on `dma_rdata` in one acknowledge, with long j in bits 32j+31..32j.
- R10: A core that raises a request in any clock, and holds it, is acknowledged at most 10 clocks later. A core that raises a new request in the clock of its previous acknowledge waits exactly 10 clocks.
- R11: In the clock of any acknowledge, `rsp_slot` equals the slot index that served the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 8 | Per-core request, held until acknowledged |
| core_we | input | 8 | Per-core direction, 1 = write |
| core_addr | input | 8*CORE_AW (72) | Per-core long address, core k in bits k*CORE_AW upward |
| core_wdata | input | 256 | Per-core write long, core k in bits 32k+31..32k |
| core_be | input | 32 | Per-core byte enables, core k in bits 4k+3..4k |
| core_ack | output | 8 | One-hot acknowledge, one clock after the core's slot |
| core_rdata | output | 32 | Read long for the acknowledged core |
| dma_req | input | 1 | DMA request, held until acknowledged |
| dma_we | input | 1 | DMA direction, 1 = write |
| dma_addr | input | LINE_AW (6) | DMA line address |
| dma_wdata | input | 256 | DMA write line |
| dma_ack | output | 1 | DMA acknowledge, one clock after a DMA slot |
| dma_rdata | output | 256 | DMA read line |
| slot_now | output | 4 | Index of the slot in progress |
| rsp_slot | output | 4 | Index of the slot that served the current acknowledge |

## Verification
The bench chases the cases a slot scheme is most likely to get wrong. The first is the seam where the counter wraps from 9 to 0: an off-by-one there would shift every later owner or stretch the rotation to 11 slots. The second is a core queueing a new request in the same clock as its previous acknowledge; a design that served a held request twice, or lent idle slots to waiting cores, would show acknowledges in the wrong clock. The third is byte enables with mixed and empty patterns, where a wrong lane shift would corrupt a neighbouring long. The fourth is whole-line DMA traffic read back one long at a time by the cores, where a swapped long order would surface at once. A reset while an access is about to be acknowledged must leave no acknowledge behind.

// File: rtl/hubarb_pkg.sv
package hubarb_pkg;

    localparam int NUM_CORES       = 8;
    localparam int DMA_SLOTS       = 2;
    localparam int SLOTS           = NUM_CORES + DMA_SLOTS;
    localparam int SLOT_W          = $clog2(SLOTS);
    localparam int CORES_PER_GROUP = NUM_CORES / DMA_SLOTS;
    localparam int GROUP_SLOTS     = CORES_PER_GROUP + 1;
    localparam int CORE_ID_W       = $clog2(NUM_CORES);

    localparam int WORD_W      = 32;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int LINE_LONGS  = 8;
    localparam int LINE_W      = WORD_W * LINE_LONGS;
    localparam int LINE_BYTES  = LINE_W / 8;
    localparam int LANE_W      = $clog2(LINE_LONGS);

    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [CORE_ID_W-1:0] core_id_t;
    typedef logic [LANE_W-1:0]    lane_t;

    // Who owns a slot: the DMA port or one core.
    typedef struct packed {
        logic     is_dma;
        core_id_t core;
    } owner_t;

    // Registered response returned one clock after the slot.
    typedef struct packed {
        logic [NUM_CORES-1:0] core_ack;
        logic                 dma_ack;
        lane_t                lane;
        slot_t                tag;
    } rsp_t;

    // Each group is CORES_PER_GROUP core slots followed by one DMA slot.
    function automatic owner_t slot_owner(input slot_t s);
        owner_t o;
        int     grp;
        int     pos;
        grp      = int'(s) / GROUP_SLOTS;
        pos      = int'(s) % GROUP_SLOTS;
        o.is_dma = (pos == CORES_PER_GROUP);
        o.core   = o.is_dma ? '0 : core_id_t'(grp * CORES_PER_GROUP + pos);
        return o;
    endfunction

    function automatic slot_t next_slot(input slot_t s);
        return (s == slot_t'(SLOTS - 1)) ? '0 : s + slot_t'(1);
    endfunction

endpackage

// File: rtl/hubarb_slot_seq.sv
module hubarb_slot_seq
    import hubarb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output slot_t  slot_q,
    output owner_t owner
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= next_slot(slot_q);
        end
    end

    assign owner = slot_owner(slot_q);

endmodule

// File: rtl/hubarb_req_mux.sv
module hubarb_req_mux
    import hubarb_pkg::*;
#(
    parameter int LINE_AW = 6,
    parameter int CORE_AW = LINE_AW + LANE_W
) (
    input  owner_t                          owner,
    input  logic [NUM_CORES-1:0]            core_req,
    input  logic [NUM_CORES-1:0]            core_we,
    input  logic [NUM_CORES*CORE_AW-1:0]    core_addr,
    input  logic [NUM_CORES*WORD_W-1:0]     core_wdata,
    input  logic [NUM_CORES*WORD_BYTES-1:0] core_be,
    input  logic                            dma_req,
    input  logic                            dma_we,
    input  logic [LINE_AW-1:0]              dma_addr,
    input  logic [LINE_W-1:0]               dma_wdata,
    output logic [NUM_CORES-1:0]            grant_core,
    output logic                            grant_dma,
    output logic                            ram_en,
    output logic                            ram_we,
    output logic [LINE_AW-1:0]              ram_addr,
    output logic [LINE_W-1:0]               ram_wdata,
    output logic [LINE_BYTES-1:0]           ram_be,
    output lane_t                           ram_lane
);

    logic [CORE_AW-1:0]    c_addr  [NUM_CORES];
    logic [WORD_W-1:0]     c_wdata [NUM_CORES];
    logic [WORD_BYTES-1:0] c_be    [NUM_CORES];

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_unpack
        assign c_addr[g]  = core_addr[g*CORE_AW +: CORE_AW];
        assign c_wdata[g] = core_wdata[g*WORD_W +: WORD_W];
        assign c_be[g]    = core_be[g*WORD_BYTES +: WORD_BYTES];
    end

    logic [CORE_AW-1:0] sel_addr;
    lane_t              sel_lane;

    assign sel_addr = c_addr[owner.core];
    assign sel_lane = sel_addr[LANE_W-1:0];

    always_comb begin
        grant_core = '0;
        grant_dma  = 1'b0;
        ram_en     = 1'b0;
        ram_we     = 1'b0;
        ram_addr   = '0;
        ram_wdata  = '0;
        ram_be     = '0;
        ram_lane   = '0;
        if (owner.is_dma) begin
            if (dma_req) begin
                grant_dma = 1'b1;
                ram_en    = 1'b1;
                ram_we    = dma_we;
                ram_addr  = dma_addr;
                ram_wdata = dma_wdata;
                ram_be    = '1;
            end
        end else if (core_req[owner.core]) begin
            grant_core[owner.core] = 1'b1;
            ram_en    = 1'b1;
            ram_we    = core_we[owner.core];
            ram_addr  = sel_addr[CORE_AW-1:LANE_W];
            ram_lane  = sel_lane;
            ram_wdata = {LINE_LONGS{c_wdata[owner.core]}};
            ram_be    = LINE_BYTES'(c_be[owner.core]) << (int'(sel_lane) * WORD_BYTES);
        end
    end

endmodule

// File: rtl/hubarb_line_ram.sv
module hubarb_line_ram
    import hubarb_pkg::*;
#(
    parameter int LINES   = 64,
    parameter int LINE_AW = $clog2(LINES)
) (
    input  logic                  clk,
    input  logic                  en,
    input  logic                  we,
    input  logic [LINE_AW-1:0]    addr,
    input  logic [LINE_W-1:0]     wdata,
    input  logic [LINE_BYTES-1:0] be,
    output logic [LINE_W-1:0]     rdata
);

    logic [LINE_W-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int b = 0; b < LINE_BYTES; b++) begin
                    if (be[b]) begin
                        mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
                    end
                end
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
    import hubarb_pkg::*;
#(
    parameter int LINES   = 64,
    parameter int LINE_AW = $clog2(LINES),
    parameter int CORE_AW = LINE_AW + LANE_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CORES-1:0]            core_req,
    input  logic [NUM_CORES-1:0]            core_we,
    input  logic [NUM_CORES*CORE_AW-1:0]    core_addr,
    input  logic [NUM_CORES*WORD_W-1:0]     core_wdata,
    input  logic [NUM_CORES*WORD_BYTES-1:0] core_be,
    output logic [NUM_CORES-1:0]            core_ack,
    output logic [WORD_W-1:0]               core_rdata,
    input  logic                            dma_req,
    input  logic                            dma_we,
    input  logic [LINE_AW-1:0]              dma_addr,
    input  logic [LINE_W-1:0]               dma_wdata,
    output logic                            dma_ack,
    output logic [LINE_W-1:0]               dma_rdata,
    output logic [SLOT_W-1:0]               slot_now,
    output logic [SLOT_W-1:0]               rsp_slot
);

    slot_t  slot_q;
    owner_t owner;

    logic [NUM_CORES-1:0]  grant_core;
    logic                  grant_dma;
    logic                  ram_en;
    logic                  ram_we;
    logic [LINE_AW-1:0]    ram_addr;
    logic [LINE_W-1:0]     ram_wdata;
    logic [LINE_BYTES-1:0] ram_be;
    lane_t                 ram_lane;
    logic [LINE_W-1:0]     ram_rdata;
    rsp_t                  rsp_q;

    hubarb_slot_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .slot_q (slot_q),
        .owner  (owner)
    );

    hubarb_req_mux #(
        .LINE_AW (LINE_AW),
        .CORE_AW (CORE_AW)
    ) u_mux (
        .owner      (owner),
        .core_req   (core_req),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .core_be    (core_be),
        .dma_req    (dma_req),
        .dma_we     (dma_we),
        .dma_addr   (dma_addr),
        .dma_wdata  (dma_wdata),
        .grant_core (grant_core),
        .grant_dma  (grant_dma),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_be     (ram_be),
        .ram_lane   (ram_lane)
    );

    hubarb_line_ram #(
        .LINES   (LINES),
        .LINE_AW (LINE_AW)
    ) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .be    (ram_be),
        .rdata (ram_rdata)
    );

    // Response stage: acknowledge and tag one clock after the slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.core_ack <= grant_core;
            rsp_q.dma_ack  <= grant_dma;
            if (ram_en) begin
                rsp_q.lane <= ram_lane;
                rsp_q.tag  <= slot_q;
            end
        end
    end

    logic [WORD_W-1:0] lane_view [LINE_LONGS];

    for (genvar g = 0; g < LINE_LONGS; g++) begin : g_lane
        assign lane_view[g] = ram_rdata[g*WORD_W +: WORD_W];
    end

    assign core_ack   = rsp_q.core_ack;
    assign dma_ack    = rsp_q.dma_ack;
    assign core_rdata = lane_view[rsp_q.lane];
    assign dma_rdata  = ram_rdata;
    assign slot_now   = slot_q;
    assign rsp_slot   = rsp_q.tag;

endmodule

// File: rtl/hubarb_chk.sv
module hubarb_chk
    import hubarb_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [SLOT_W-1:0]    slot_now,
    input logic [NUM_CORES-1:0] core_req,
    input logic                 dma_req,
    input logic [NUM_CORES-1:0] core_ack,
    input logic                 dma_ack,
    input logic [SLOT_W-1:0]    rsp_slot
);

    owner_t own_w;
    logic   owner_req;
    logic   any_ack;

    assign own_w     = slot_owner(slot_now);
    assign owner_req = own_w.is_dma ? dma_req : core_req[own_w.core];
    assign any_ack   = dma_ack | (|core_ack);

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (slot_now != SLOT_W'(SLOTS - 1)) |=> (slot_now == $past(slot_now) + SLOT_W'(1))); // R2
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (slot_now == SLOT_W'(SLOTS - 1)) |=> (slot_now == '0)); // R2
    AST_CORE_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        (|core_ack) |-> (!$past(own_w.is_dma) &&
                         core_ack == (NUM_CORES'(1) << $past(own_w.core)))); // R3
    AST_DMA_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        dma_ack |-> ($past(own_w.is_dma) && $past(dma_req))); // R3
    AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dma_ack, core_ack})); // R4
    AST_OWNER_SERVED: assert property (@(posedge clk) disable iff (rst)
        owner_req |=> any_ack); // R4
    AST_IDLE_UNUSED: assert property (@(posedge clk) disable iff (rst)
        !owner_req |=> !any_ack); // R5
    AST_TAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        any_ack |-> (rsp_slot == $past(slot_now))); // R11

endmodule

bind hub_slot_arbiter hubarb_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .slot_now (slot_now),
    .core_req (core_req),
    .dma_req  (dma_req),
    .core_ack (core_ack),
    .dma_ack  (dma_ack),
    .rsp_slot (rsp_slot)
);

// File: tb/test_hub_slot_arbiter.sv
module test_hub_slot_arbiter;
    import hubarb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 64;
    localparam int LINE_AW    = $clog2(LINES);
    localparam int CORE_AW    = LINE_AW + LANE_W;
    localparam int NC         = NUM_CORES;
    localparam int DMA_ID     = NC;
    localparam int TEST_LONGS = 64;   // lines 0..7 only

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [NC-1:0]              core_req = '0;
    logic [NC-1:0]              core_we = '0;
    logic [NC*CORE_AW-1:0]      core_addr = '0;
    logic [NC*WORD_W-1:0]       core_wdata = '0;
    logic [NC*WORD_BYTES-1:0]   core_be = '0;
    logic [NC-1:0]              core_ack;
    logic [WORD_W-1:0]          core_rdata;
    logic                       dma_req = 1'b0;
    logic                       dma_we = 1'b0;
    logic [LINE_AW-1:0]         dma_addr = '0;
    logic [LINE_W-1:0]          dma_wdata = '0;
    logic                       dma_ack;
    logic [LINE_W-1:0]          dma_rdata;
    logic [SLOT_W-1:0]          slot_now;
    logic [SLOT_W-1:0]          rsp_slot;

    always #(CLK_PERIOD/2) clk = ~clk;

    hub_slot_arbiter #(.LINES(LINES)) i_hub_slot_arbiter (
        .clk(clk), .rst(rst),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_be(core_be),
        .core_ack(core_ack), .core_rdata(core_rdata),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
        .dma_wdata(dma_wdata), .dma_ack(dma_ack), .dma_rdata(dma_rdata),
        .slot_now(slot_now), .rsp_slot(rsp_slot)
    );

    typedef struct {
        bit        we;
        int        addr;
        bit [31:0] data;
        bit [3:0]  be;
        int        gap;
    } cop_t;

    typedef struct {
        bit              we;
        int              line;
        bit [LINE_W-1:0] data;
        int              gap;
    } dop_t;

    cop_t cq [NC][$];
    dop_t dq [$];
    bit   cbusy [NC];
    cop_t ccur [NC];
    int   cstart [NC];
    int   maxwait [NC];
    bit   dbusy;
    dop_t dcur;

    bit [31:0]       ref_mem [TEST_LONGS];
    int              m_slot;
    int              exp_owner;
    int              exp_tag;
    bit              exp_rd;
    bit [31:0]       exp_word;
    bit [LINE_W-1:0] exp_line;

    int        cyc;
    int        checks;
    int        failures;
    bit [31:0] lcg = 32'h1234_5678;

    function automatic bit [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Rotation written from the requirement list (R2).
    function automatic int owner_of(int s);
        if (s == 4 || s == 9) return DMA_ID;
        if (s < 4) return s;
        return s - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic drive();
        for (int k = 0; k < NC; k++) begin
            core_req[k]                         = cbusy[k];
            core_we[k]                          = cbusy[k] && ccur[k].we;
            core_addr[k*CORE_AW +: CORE_AW]     = CORE_AW'(ccur[k].addr);
            core_wdata[k*WORD_W +: WORD_W]      = ccur[k].data;
            core_be[k*WORD_BYTES +: WORD_BYTES] = ccur[k].be;
        end
        dma_req   = dbusy;
        dma_we    = dbusy && dcur.we;
        dma_addr  = LINE_AW'(dcur.line);
        dma_wdata = dcur.data;
    endtask

    task automatic clear_state();
        for (int k = 0; k < NC; k++) begin
            cq[k].delete();
            cbusy[k] = 1'b0;
            ccur[k]  = '{0, 0, 0, 0, 0};
        end
        dq.delete();
        dbusy     = 1'b0;
        dcur      = '{0, 0, '0, 0};
        m_slot    = 0;
        exp_owner = -1;
        drive();
    endtask

    // One clock of the reference model, evaluated at a falling edge.
    task automatic step();
        logic [NC-1:0] ec;
        int o;
        int idx;
        ec = (exp_owner >= 0 && exp_owner < NC) ? (NC'(1) << exp_owner) : '0;

        chk(slot_now == SLOT_W'(m_slot), "R2",
            $sformatf("slot actual=%0d expected=%0d", slot_now, m_slot));
        if (exp_owner < 0) begin
            chk(core_ack == '0 && !dma_ack, "R5",
                $sformatf("acks actual=%b/%b expected=0/0", core_ack, dma_ack));
        end else begin
            chk(core_ack == ec && dma_ack == (exp_owner == DMA_ID), "R4",
                $sformatf("acks actual=%b/%b expected=%b/%b", core_ack, dma_ack,
                          ec, exp_owner == DMA_ID));
            chk(rsp_slot == SLOT_W'(exp_tag), "R11",
                $sformatf("tag actual=%0d expected=%0d", rsp_slot, exp_tag));
            if (exp_rd && exp_owner < NC)
                chk(core_rdata == exp_word, "R7",
                    $sformatf("core%0d rdata actual=%h expected=%h", exp_owner, core_rdata, exp_word));
            if (exp_rd && exp_owner == DMA_ID)
                chk(dma_rdata == exp_line, "R9",
                    $sformatf("dma rdata actual=%h expected=%h", dma_rdata, exp_line));
            if (exp_owner < NC) begin
                chk(cyc - cstart[exp_owner] <= SLOTS, "R10",
                    $sformatf("core%0d wait actual=%0d expected<=%0d",
                              exp_owner, cyc - cstart[exp_owner], SLOTS));
                if (cyc - cstart[exp_owner] > maxwait[exp_owner])
                    maxwait[exp_owner] = cyc - cstart[exp_owner];
                cbusy[exp_owner] = 1'b0;
            end else begin
                dbusy = 1'b0;
            end
        end

        for (int k = 0; k < NC; k++) begin
            if (!cbusy[k] && cq[k].size() > 0) begin
                if (cq[k][0].gap > 0) cq[k][0].gap -= 1;
                else begin
                    ccur[k]   = cq[k].pop_front();
                    cbusy[k]  = 1'b1;
                    cstart[k] = cyc;
                end
            end
        end
        if (!dbusy && dq.size() > 0) begin
            if (dq[0].gap > 0) dq[0].gap -= 1;
            else begin
                dcur  = dq.pop_front();
                dbusy = 1'b1;
            end
        end
        drive();

        o = owner_of(m_slot);
        exp_owner = -1;
        exp_tag   = m_slot;
        if (o < NC && cbusy[o]) begin
            exp_owner = o;
            exp_rd    = !ccur[o].we;
            idx       = ccur[o].addr;
            if (ccur[o].we) begin
                for (int b = 0; b < 4; b++)
                    if (ccur[o].be[b]) ref_mem[idx][b*8 +: 8] = ccur[o].data[b*8 +: 8];
            end else begin
                exp_word = ref_mem[idx];
            end
        end else if (o == DMA_ID && dbusy) begin
            exp_owner = DMA_ID;
            exp_rd    = !dcur.we;
            for (int j = 0; j < LINE_LONGS; j++) begin
                if (dcur.we) ref_mem[dcur.line*8 + j] = dcur.data[j*32 +: 32];
                else exp_line[j*32 +: 32] = ref_mem[dcur.line*8 + j];
            end
        end
        m_slot = (m_slot + 1) % SLOTS;
        cyc++;
    endtask

    function automatic bit pending();
        bit p;
        p = dbusy || dq.size() > 0;
        for (int k = 0; k < NC; k++) p = p || cbusy[k] || cq[k].size() > 0;
        return p;
    endfunction

    task automatic run(input string name);
        int n;
        n = 0;
        while (pending()) begin
            step();
            @(negedge clk);
            n++;
            if (n > 20000) begin
                chk(1'b0, "R10", $sformatf("phase %s did not drain actual=%0d expected<=20000", name, n));
                break;
            end
        end
        step();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        summary();
    end

    initial begin
        bit [LINE_W-1:0] ln;
        bit [3:0] be_pat [5];
        checks   = 0;
        failures = 0;
        cyc      = 0;
        clear_state();
        for (int k = 0; k < NC; k++) maxwait[k] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(slot_now == '0, "R1", $sformatf("slot in reset actual=%0d expected=0", slot_now));
        chk(core_ack == '0 && !dma_ack, "R1",
            $sformatf("acks in reset actual=%b/%b expected=0/0", core_ack, dma_ack));
        rst = 1'b0;

        // R8: DMA line writes fill lines 0..7
        for (int l = 0; l < 8; l++) begin
            for (int j = 0; j < LINE_LONGS; j++) ln[j*32 +: 32] = rnd();
            dq.push_back('{1, l, ln, 0});
        end
        run("dma_fill");

        // R7, R8: cores read DMA-written longs in several lanes
        for (int k = 0; k < NC; k++)
            for (int j = 0; j < LINE_LONGS; j++)
                cq[k].push_back('{0, ((k + j) % 8) * 8 + j, 32'h0, 4'h0, 0});
        run("core_read");

        // R10: back-to-back core writes, with DMA line reads (R9)
        for (int k = 0; k < NC; k++) begin
            maxwait[k] = 0;
            for (int n = 0; n < 6; n++) cq[k].push_back('{1, k*8 + n, rnd(), 4'hF, 0});
        end
        for (int l = 0; l < 8; l++) dq.push_back('{0, l, '0, 0});
        run("back_to_back");
        for (int k = 0; k < NC; k++)
            chk(maxwait[k] == SLOTS, "R10",
                $sformatf("core%0d worst wait actual=%0d expected=%0d", k, maxwait[k], SLOTS));

        // R6: partial and empty byte enables, each followed by a read
        be_pat = '{4'b0001, 4'b0110, 4'b1000, 4'b1010, 4'b0000};
        for (int k = 0; k < NC; k++)
            for (int p = 0; p < 5; p++) begin
                cq[k].push_back('{1, k*8 + 7, rnd(), be_pat[p], 0});
                cq[k].push_back('{0, k*8 + 7, 32'h0, 4'h0, 0});
                cq[k].push_back('{0, ((k + 1) % 8)*8 + 6, 32'h0, 4'h0, 0});
            end
        run("byte_enable");

        // R5: one core active, all other slots idle
        for (int n = 0; n < 12; n++)
            cq[3].push_back('{n[0], 8*n[2:0] + 3, rnd(), 4'hF, n});
        run("single_core");

        // R3, R4: random mix of gaps, directions and enables
        for (int k = 0; k < NC; k++)
            for (int n = 0; n < 40; n++)
                cq[k].push_back('{rnd() % 2 == 0, int'(rnd() % TEST_LONGS), rnd(),
                                  4'(rnd()), int'(rnd() % 16)});
        for (int n = 0; n < 20; n++) begin
            for (int j = 0; j < LINE_LONGS; j++) ln[j*32 +: 32] = rnd();
            dq.push_back('{rnd() % 2 == 0, int'(rnd() % 8), ln, int'(rnd() % 12)});
        end
        run("random_mix");

        // R1: reset applied while an acknowledge is about to be registered
        for (int k = 0; k < NC; k++) cq[k].push_back('{0, k, 32'h0, 4'h0, 0});
        for (int n = 0; n < 30; n++) begin
            step();
            if (exp_owner >= 0) break;
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
        chk(core_ack == '0 && !dma_ack, "R1",
            $sformatf("acks after reset actual=%b/%b expected=0/0", core_ack, dma_ack));
        chk(slot_now == '0, "R1", $sformatf("slot after reset actual=%0d expected=0", slot_now));
        clear_state();
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NC; k++) cq[k].push_back('{0, k*9 % TEST_LONGS, 32'h0, 4'h0, k});
        dq.push_back('{0, 5, '0, 3});
        run("after_reset");

        summary();
    end

endmodule